// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns one operand specifier into a memory operand. A request carries a 3-bit mode code, the base register number, the current values of the base and index registers, a 32-bit constant and a 2-bit scale code. The unit forms the effective address, reads memory once, or twice for the chained pointer mode, and hands back the fetched word. For the two stepping modes it also returns the updated base register on a write-back port. The caller writes that value into its register file.

Requests are accepted with a valid/ready pair. Each request runs to completion before the next one is taken. The memory port is a plain synchronous read: the unit raises `mem_rd_en` with an address, and the word is expected on `mem_rd_data` in the following cycle. The result is offered with a second valid/ready pair. The write-back strobe fires only in the cycle the result is taken.

Top module: `ea_operand_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `res_valid`, `mem_rd_en` and `wb_en` are 0.
- R2: The mode codes are 0 absolute (address = c), 1 register indirect (address = xv), 2 displacement (address = xv + c) and 3 indexed (address = xv + yv). All sums are modulo 2^32, and the fetched word is returned on `res_data`.
- R3: Mode 7 (scaled) reads at xv + c + (yv << s). The scale code s takes the values 0, 1, 2 and 3, which multiply the index by 1, 2, 4 and 8.
- R4: Mode 4 (chained pointer) first reads at xv. It then reads at the word that first read returned, and returns the word from the second read.
- R5: Mode 5 (post-step) reads at xv. It writes xv + 4 back to register `req_xidx`.
- R6: Mode 6 (pre-step) reads at xv - 4. It writes xv - 4 back to register `req_xidx`. The step wraps modulo 2^32.
- R7: Modes 0, 1, 2, 3, 4 and 7 never assert `wb_en`.
- R8: `mem_rd_en` is high in the cycle after acceptance. Every mode except mode 4 makes exactly one read, with `res_valid` high two cycles after acceptance. Mode 4 makes exactly two reads, with `res_valid` high four cycles after acceptance.
- R9: While `res_ready` is 0, `res_valid` stays high and `res_data` stays stable. `req_ready` stays low from acceptance until the result is taken.
- R10: `wb_en` is high only in a cycle where `res_valid` and `res_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit is idle and takes a request |
| req_mode | input | 3 | Addressing mode code |
| req_xidx | input | 5 | Base register number, used for write-back |
| req_xval | input | 32 | Base register value |
| req_yval | input | 32 | Index register value |
| req_const | input | 32 | Constant from the instruction |
| req_scale | input | 2 | Index shift code, 0 to 3 |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| res_valid | output | 1 | Operand result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Fetched operand |
| wb_en | output | 1 | Base register write-back strobe |
| wb_idx | output | 5 | Register to write |
| wb_data | output | 32 | Updated base value |

## Verification
The hardest cases to reach from the ports are the chained pointer mode while the consumer stalls, and the stepping modes at the 32-bit boundary. In the first, the second address exists only as data that memory returned. The bench's memory returns a hashed function of the address, so every chained second address is distinct and can be predicted. Random requests run with random result stalls. Directed cases place the base at 0 and at 0xFFFFFFFC to make the step wrap, and sweep every scale code.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        AM_ABS  = 3'd0,
        AM_IND  = 3'd1,
        AM_DISP = 3'd2,
        AM_IDX  = 3'd3,
        AM_CHAIN = 3'd4,
        AM_POST = 3'd5,
        AM_PRE  = 3'd6,
        AM_SCL  = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CAPT = 2'd2,
        ST_DONE = 2'd3
    } st_e;
endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 2
) (
    input  logic [2:0]    mode,
    input  logic [DW-1:0] xval,
    input  logic [DW-1:0] yval,
    input  logic [DW-1:0] cval,
    input  logic [SW-1:0] scale,
    output logic [DW-1:0] ea,
    output logic          chain,
    output logic          wb_need,
    output logic [DW-1:0] wb_val
);
    localparam logic [DW-1:0] STEP = DW'(DW / 8);

    logic [DW-1:0] scaled_y;
    logic [DW-1:0] x_up;
    logic [DW-1:0] x_dn;

    always_comb begin
        scaled_y = yval << scale;
        x_up     = xval + STEP;
        x_dn     = xval - STEP;
        ea       = xval;
        chain    = 1'b0;
        wb_need  = 1'b0;
        wb_val   = x_up;
        case (am_e'(mode))
            AM_ABS:   ea = cval;
            AM_IND:   ea = xval;
            AM_DISP:  ea = xval + cval;
            AM_IDX:   ea = xval + yval;
            AM_CHAIN: begin
                ea    = xval;
                chain = 1'b1;
            end
            AM_POST: begin
                ea      = xval;
                wb_need = 1'b1;
                wb_val  = x_up;
            end
            AM_PRE: begin
                ea      = x_dn;
                wb_need = 1'b1;
                wb_val  = x_dn;
            end
            AM_SCL:   ea = xval + cval + scaled_y;
            default:  ea = xval;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [DW-1:0] ea,
    input  logic          chain,
    input  logic          wb_need,
    input  logic [DW-1:0] wb_val,
    input  logic [RW-1:0] x_idx,
    output logic          mem_rd_en,
    output logic [DW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [DW-1:0] res_data,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data
);
    typedef struct packed {
        st_e           st;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
        logic          chain;
        logic          wb;
        logic [RW-1:0] widx;
        logic [DW-1:0] wval;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_READ;
                    seq_d.addr  = ea;
                    seq_d.chain = chain;
                    seq_d.wb    = wb_need;
                    seq_d.widx  = x_idx;
                    seq_d.wval  = wb_val;
                end
            end
            ST_READ: seq_d.st = ST_CAPT;
            ST_CAPT: begin
                if (seq_q.chain) begin
                    seq_d.addr  = mem_rd_data;
                    seq_d.chain = 1'b0;
                    seq_d.st    = ST_READ;
                end else begin
                    seq_d.data = mem_rd_data;
                    seq_d.st   = ST_DONE;
                end
            end
            ST_DONE: if (res_ready) seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready   = (seq_q.st == ST_IDLE);
    assign mem_rd_en   = (seq_q.st == ST_READ);
    assign mem_rd_addr = seq_q.addr;
    assign res_valid   = (seq_q.st == ST_DONE);
    assign res_data    = seq_q.data;
    assign wb_en       = res_valid && res_ready && seq_q.wb;
    assign wb_idx      = seq_q.widx;
    assign wb_data     = seq_q.wval;

    // R8
    read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);

    // R8
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8
    result_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(mem_rd_en, 2));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
    import eag_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 5,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_mode,
    input  logic [RW-1:0] req_xidx,
    input  logic [DW-1:0] req_xval,
    input  logic [DW-1:0] req_yval,
    input  logic [DW-1:0] req_const,
    input  logic [SW-1:0] req_scale,
    output logic          mem_rd_en,
    output logic [DW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [DW-1:0] res_data,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data
);
    logic [DW-1:0] ea;
    logic          chain;
    logic          wb_need;
    logic [DW-1:0] wb_val;

    eag_addr_calc #(.DW(DW), .SW(SW)) calc_i (
        .mode    (req_mode),
        .xval    (req_xval),
        .yval    (req_yval),
        .cval    (req_const),
        .scale   (req_scale),
        .ea      (ea),
        .chain   (chain),
        .wb_need (wb_need),
        .wb_val  (wb_val)
    );

    eag_seq #(.DW(DW), .RW(RW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .ea          (ea),
        .chain       (chain),
        .wb_need     (wb_need),
        .wb_val      (wb_val),
        .x_idx       (req_xidx),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data)
    );

    // R10
    wb_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (res_valid && res_ready));

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (req_ready && !res_valid && !mem_rd_en && !wb_en));
endmodule

// File: tb/ea_operand_unit_tb.sv
`timescale 1ns/1ps
module ea_operand_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_mode = '0;
    logic [4:0]  req_xidx = '0;
    logic [31:0] req_xval = '0, req_yval = '0, req_const = '0;
    logic [1:0]  req_scale = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_data;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ea_operand_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_xidx(req_xidx),
        .req_xval(req_xval), .req_yval(req_yval),
        .req_const(req_const), .req_scale(req_scale),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        logic [31:0] h;
        h = (a ^ 32'h5A17C3E9) * 32'h9E3779B1;
        return h ^ (h >> 13);
    endfunction

    function automatic logic [31:0] ea_f(input logic [2:0] m, input logic [31:0] xv, yv, c,
                                         input logic [1:0] s);
        case (m)
            3'd0: return c;
            3'd2: return xv + c;
            3'd3: return xv + yv;
            3'd6: return xv - 32'd4;
            3'd7: return xv + c + (yv << s);
            default: return xv;
        endcase
    endfunction

    function automatic string tag_f(input logic [2:0] m);
        case (m)
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            3'd7: return "R3";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_f(mem_rd_addr);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [4:0] xi,
                          input logic [31:0] xv, yv, c, input logic [1:0] s, input int hold);
        logic [31:0] e_addr, e_data, e_wb, a0, a1, held;
        int n_rd, lat, e_lat;
        bit e_wbn, busy_ok;
        string t;
        t      = tag_f(m);
        e_addr = ea_f(m, xv, yv, c, s);
        e_data = (m == 3'd4) ? mem_f(mem_f(e_addr)) : mem_f(e_addr);
        e_lat  = (m == 3'd4) ? 4 : 2;
        e_wbn  = (m == 3'd5) || (m == 3'd6);
        e_wb   = (m == 3'd5) ? xv + 32'd4 : xv - 32'd4;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_mode = m; req_xidx = xi; req_xval = xv;
        req_yval = yv; req_const = c; req_scale = s;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_xval = ~xv; req_const = ~c;
        n_rd = 0; lat = 0; a0 = '0; a1 = '0; busy_ok = 1'b1;
        while (!res_valid && lat < 20) begin
            if (!req_ready == 1'b0) busy_ok = 1'b0;
            if (mem_rd_en) begin
                if (n_rd == 0) a0 = mem_rd_addr; else a1 = mem_rd_addr;
                n_rd++;
            end
            lat++;
            @(negedge clk);
        end
        chk(busy_ok, "R9 req_ready low while busy", 32'(busy_ok), 32'd1);
        chk(lat == e_lat, "R8 latency", 32'(lat), 32'(e_lat));
        chk(n_rd == ((m == 3'd4) ? 2 : 1), "R8 read count", 32'(n_rd), (m == 3'd4) ? 32'd2 : 32'd1);
        chk(a0 == e_addr, {t, " first read address"}, a0, e_addr);
        if (m == 3'd4)
            chk(a1 == mem_f(e_addr), "R4 second read address", a1, mem_f(e_addr));
        held = res_data;
        for (int i = 0; i < hold; i++) begin
            chk(res_valid && res_data == held && !wb_en && !req_ready,
                "R9 hold/R10 no wb while stalled", res_data, held);
            @(negedge clk);
        end
        res_ready = 1'b1;
        #0.5;
        chk(res_valid && res_data == e_data, {t, " operand data"}, res_data, e_data);
        chk(wb_en == e_wbn, e_wbn ? {t, " wb_en"} : "R7 no write-back", 32'(wb_en), 32'(e_wbn));
        if (e_wbn) begin
            chk(wb_idx == xi, {t, " wb_idx"}, 32'(wb_idx), 32'(xi));
            chk(wb_data == e_wb, {t, " wb_data"}, wb_data, e_wb);
        end
        @(posedge clk);
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && !wb_en, "R10 wb/result gone after handshake", 32'(wb_en), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(!res_valid && !mem_rd_en && !wb_en, "R1 idle outputs",
            {29'd0, res_valid, mem_rd_en, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_rd_en, "R1 idle after release", 32'(req_ready), 32'd1);

        // directed: every mode
        for (int m = 0; m < 8; m++)
            run_op(3'(m), 5'(m + 3), 32'h0000_1000 + 32'(m), 32'h20, 32'h40, 2'd1, 0);
        // R3 every scale code
        for (int s = 0; s < 4; s++)
            run_op(3'd7, 5'd9, 32'h100, 32'h13, 32'h8, 2'(s), 0);
        // R5/R6 wrap boundaries
        run_op(3'd6, 5'd31, 32'h0000_0000, '0, '0, 2'd0, 0);
        run_op(3'd5, 5'd0, 32'hFFFF_FFFC, '0, '0, 2'd0, 0);
        // R2 modular sums
        run_op(3'd2, 5'd1, 32'hFFFF_FFF0, '0, 32'h20, 2'd0, 0);
        run_op(3'd3, 5'd1, 32'h8000_0000, 32'h8000_0004, '0, 2'd0, 0);
        // R9/R4 stalled chained pointer
        run_op(3'd4, 5'd7, 32'hDEAD_BEE0, '0, '0, 2'd0, 5);
        run_op(3'd5, 5'd12, 32'h44, '0, '0, 2'd0, 3);

        // random
        for (int k = 0; k < 300; k++)
            run_op(3'($urandom_range(0, 7)), 5'($urandom), $urandom, $urandom, $urandom,
                   2'($urandom_range(0, 3)), $urandom_range(0, 3));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule